// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives the sync and enable outputs of a TFT panel. It produces a horizontal sync, a vertical sync, a data-enable strobe, a pixel clock and the raw pixel and line positions. All of these come from three 32-bit timing words, plus three polarity controls, that a configuration side writes. Most horizontal quantities are stored as the value minus one and spread across two words. The active width is counted in blocks of sixteen pixels. The vertical porches are stored as their plain values.

Each line runs in this order: back porch, active pixels, front porch, sync. Each frame runs in the same order over lines. Because the sync comes last in a line, vertical sync changes only at the trailing edge of horizontal sync. The geometry and the polarities are captured once at the start of every frame, so a write made in the middle of a frame takes effect at the next frame. If the enable is low when a frame finishes, the generator stops at that point and pulses a frame-done output.

Top module: `lcd_raster_timing`

## Requirements
- R1: Horizontal fields are each ten bits and hold the value minus one. Back porch is tw0[31:24] with tw2[5:4] as its top two bits. Front porch is tw0[23:16] with tw2[1:0] as its top two bits. Sync width is tw0[15:10] with tw2[30:27] as its top four bits.
- R2: Active width equals (code + 1) * 16 pixels. The seven-bit code is tw0[9:4], with tw0[3] as its most significant bit.
- R3: Lines per frame minus one is tw1[9:0], with tw2[26] as bit 10. The vertical back porch is tw1[31:24] and the vertical front porch is tw1[23:16], both in lines with no offset. Vertical sync width minus one is tw1[15:10].
- R4: Each line runs back porch, active, front porch, sync. Horizontal sync is active for exactly the last sync-width pixels of the line.
- R5: Vertical sync is active for the last sync-width lines of a frame. It changes only at a line boundary, which is the trailing edge of horizontal sync.
- R6: Data-enable is high only on active pixels of active lines. It is never high during horizontal sync.
- R7: One pixel takes two clock cycles. With inv_pclk_i low, pclk_o is low in the first cycle of a pixel and high in the second. With inv_pclk_i high, both levels are swapped.
- R8: inv_hsync_i and inv_vsync_i make the respective sync active-low. When idle, each sync sits at its inactive level.
- R9: Raising enable from idle starts the frame at pixel 0 of line 0, the first back-porch position. hpos_o and vpos_o report the raw counters one cycle after the counters hold them.
- R10: The timing words and polarity inputs are captured at the start of a frame. Changes made during a frame have no effect until the next frame.
- R11: If enable is low when the last pixel of a frame completes, the block goes idle and pulses frame_done_o high for one cycle. Dropping enable in the middle of a frame and raising it again before the frame ends has no effect.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Raster enable |
| tw0_i | input | 32 | Horizontal timing word |
| tw1_i | input | 32 | Vertical timing word |
| tw2_i | input | 32 | Extension bits for the horizontal fields and the line count |
| inv_hsync_i | input | 1 | Horizontal sync active-low |
| inv_vsync_i | input | 1 | Vertical sync active-low |
| inv_pclk_i | input | 1 | Swap the pixel clock levels |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_o | output | 1 | Pixel clock |
| hpos_o | output | 13 | Pixel counter within the line |
| vpos_o | output | 12 | Line counter within the frame |
| frame_done_o | output | 1 | One-cycle pulse when the raster stops |

## Verification
Every output is registered from the counter state. Each output value therefore appears one clock after the state that produces it. The counters step on every second clock, and frame_done_o rises one clock after the last pixel of the final frame. The reference model advances at each rising edge and produces the value that is due at that edge. The bench compares all outputs with the model at the falling edge that follows, so each output is checked in the exact cycle it is due. Frame-done pulses are counted over a window after the enable is dropped, and exactly one pulse is expected.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int HF_W     = 10;  // horizontal porch/sync fields
  localparam int PPL_W    = 7;   // width code
  localparam int UNIT_LG2 = 4;   // width unit = 16 pixels
  localparam int VP_W     = 8;   // vertical porches
  localparam int VSW_W    = 6;   // vertical sync width
  localparam int LPP_W    = 11;  // lines per frame
  localparam int HC_W     = 13;  // horizontal counter
  localparam int VC_W     = 12;  // vertical counter

  typedef struct packed {
    logic [HC_W-1:0] act_beg;
    logic [HC_W-1:0] act_end;
    logic [HC_W-1:0] sync_beg;
    logic [HC_W-1:0] total;
  } hgeom_t;

  typedef struct packed {
    logic [VC_W-1:0] act_beg;
    logic [VC_W-1:0] act_end;
    logic [VC_W-1:0] sync_beg;
    logic [VC_W-1:0] total;
  } vgeom_t;

  typedef struct packed {
    logic inv_h;
    logic inv_v;
    logic inv_p;
  } pol_t;

  function automatic hgeom_t calc_h(input logic [31:0] w0, input logic [31:0] w2);
    logic [HF_W-1:0]  bp_m1;
    logic [HF_W-1:0]  fp_m1;
    logic [HF_W-1:0]  sw_m1;
    logic [PPL_W-1:0] ppl_m1;
    logic [HC_W-1:0]  width;
    hgeom_t g;
    bp_m1  = {w2[5:4], w0[31:24]};
    fp_m1  = {w2[1:0], w0[23:16]};
    sw_m1  = {w2[30:27], w0[15:10]};
    ppl_m1 = {w0[3], w0[9:4]};
    width  = (HC_W'(ppl_m1) + HC_W'(1)) << UNIT_LG2;
    g.act_beg  = HC_W'(bp_m1) + HC_W'(1);
    g.act_end  = g.act_beg + width;
    g.sync_beg = g.act_end + HC_W'(fp_m1) + HC_W'(1);
    g.total    = g.sync_beg + HC_W'(sw_m1) + HC_W'(1);
    return g;
  endfunction

  function automatic vgeom_t calc_v(input logic [31:0] w1, input logic [31:0] w2);
    logic [VP_W-1:0]  bp;
    logic [VP_W-1:0]  fp;
    logic [VSW_W-1:0] sw_m1;
    logic [LPP_W-1:0] lpp_m1;
    vgeom_t g;
    bp     = w1[31:24];
    fp     = w1[23:16];
    sw_m1  = w1[15:10];
    lpp_m1 = {w2[26], w1[9:0]};
    g.act_beg  = VC_W'(bp);
    g.act_end  = g.act_beg + VC_W'(lpp_m1) + VC_W'(1);
    g.sync_beg = g.act_end + VC_W'(fp);
    g.total    = g.sync_beg + VC_W'(sw_m1) + VC_W'(1);
    return g;
  endfunction
endpackage

// File: rtl/lcdt_geom_latch.sv
module lcdt_geom_latch
  import lcdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] tw0,
  input  logic [31:0] tw1,
  input  logic [31:0] tw2,
  input  pol_t        pol_in,
  output hgeom_t      hg,
  output vgeom_t      vg,
  output pol_t        pol
);
  logic unused_bits;
  assign unused_bits = ^{tw0[2:0], tw2[31], tw2[25:6], tw2[3:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hg  <= '0;
      vg  <= '0;
      pol <= '0;
    end else if (load) begin
      hg  <= calc_h(tw0, tw2);
      vg  <= calc_v(tw1, tw2);
      pol <= pol_in;
    end
  end
endmodule

// File: rtl/lcdt_axis_cnt.sv
module lcdt_axis_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         last
);
  assign last = (cnt == total - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (step)
      cnt <= last ? '0 : cnt + W'(1);
  end

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt < total));
endmodule

// File: rtl/lcdt_out_reg.sv
module lcdt_out_reg
  import lcdt_pkg::*;
#(
  parameter int HW = HC_W,
  parameter int VW = VC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ph,
  input  logic [HW-1:0] hcnt,
  input  logic [VW-1:0] vcnt,
  input  hgeom_t        hg,
  input  vgeom_t        vg,
  input  pol_t          pol,
  output logic          hs,
  output logic          vs,
  output logic          de,
  output logic          pc,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos
);
  logic hs_act, vs_act, h_act, v_act;

  always_comb begin
    hs_act = (hcnt >= hg.sync_beg);
    vs_act = (vcnt >= vg.sync_beg);
    h_act  = (hcnt >= hg.act_beg) && (hcnt < hg.act_end);
    v_act  = (vcnt >= vg.act_beg) && (vcnt < vg.act_end);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs <= 1'b0; vs <= 1'b0; de <= 1'b0; pc <= 1'b0;
      hpos <= '0; vpos <= '0;
    end else if (run) begin
      hs   <= hs_act ^ pol.inv_h;
      vs   <= vs_act ^ pol.inv_v;
      de   <= h_act && v_act;
      pc   <= ph ^ pol.inv_p;
      hpos <= hcnt;
      vpos <= vcnt;
    end else begin
      hs   <= pol.inv_h;
      vs   <= pol.inv_v;
      de   <= 1'b0;
      pc   <= pol.inv_p;
      hpos <= '0;
      vpos <= '0;
    end
  end

  assert_de_outside_sync_R6: assert property (@(posedge clk) disable iff (rst)
    de |-> (hs == pol.inv_h));
endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
  import lcdt_pkg::*;
#(
  parameter int H_W = HC_W,
  parameter int V_W = VC_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable_i,
  input  logic [31:0]    tw0_i,
  input  logic [31:0]    tw1_i,
  input  logic [31:0]    tw2_i,
  input  logic           inv_hsync_i,
  input  logic           inv_vsync_i,
  input  logic           inv_pclk_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           pclk_o,
  output logic [H_W-1:0] hpos_o,
  output logic [V_W-1:0] vpos_o,
  output logic           frame_done_o
);
  logic run_q, ph_q, done_q;
  logic start, step_px, line_end, frame_end, load;
  logic h_last, v_last;
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  hgeom_t hg;
  vgeom_t vg;
  pol_t   pol_in, pol;

  assign pol_in    = '{inv_h: inv_hsync_i, inv_v: inv_vsync_i, inv_p: inv_pclk_i};
  assign start     = !run_q && enable_i;
  assign step_px   = run_q && ph_q;
  assign line_end  = step_px && h_last;
  assign frame_end = line_end && v_last;
  assign load      = start || frame_end;

  lcdt_geom_latch u_geom (
    .clk(clk), .rst(rst), .load(load),
    .tw0(tw0_i), .tw1(tw1_i), .tw2(tw2_i), .pol_in(pol_in),
    .hg(hg), .vg(vg), .pol(pol)
  );

  lcdt_axis_cnt #(.W(H_W)) u_hcnt (
    .clk(clk), .rst(rst), .clr(start), .step(step_px),
    .total(hg.total), .cnt(h_cnt), .last(h_last)
  );

  lcdt_axis_cnt #(.W(V_W)) u_vcnt (
    .clk(clk), .rst(rst), .clr(start), .step(line_end),
    .total(vg.total), .cnt(v_cnt), .last(v_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end && !enable_i;
      if (start) begin
        run_q <= 1'b1;
        ph_q  <= 1'b0;
      end else if (run_q) begin
        ph_q <= ~ph_q;
        if (frame_end && !enable_i)
          run_q <= 1'b0;
      end else begin
        ph_q <= 1'b0;
      end
    end
  end

  assign frame_done_o = done_q;

  lcdt_out_reg #(.HW(H_W), .VW(V_W)) u_out (
    .clk(clk), .rst(rst), .run(run_q), .ph(ph_q),
    .hcnt(h_cnt), .vcnt(v_cnt), .hg(hg), .vg(vg), .pol(pol),
    .hs(hsync_o), .vs(vsync_o), .de(de_o), .pc(pclk_o),
    .hpos(hpos_o), .vpos(vpos_o)
  );

  assert_start_origin_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> (run_q && !ph_q && h_cnt == '0 && v_cnt == '0));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> !frame_done_o);

  assert_idle_after_done_R11: assert property (@(posedge clk) disable iff (rst)
    frame_done_o |=> (!de_o && hpos_o == '0 && vpos_o == '0));

  assert_vsync_at_line_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && !$stable(vsync_o)) |-> (h_cnt == '0 && ph_q));
endmodule

// File: tb/lcd_raster_timing_tb.sv
module lcd_raster_timing_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [31:0] tw0 = '0, tw1 = '0, tw2 = '0;
  logic ih = 1'b0, iv = 1'b0, ip = 1'b0;
  logic hs, vs, de, pc, fd;
  logic [12:0] hp;
  logic [11:0] vp;

  always #4 clk = ~clk;

  lcd_raster_timing u_dut (
    .clk(clk), .rst(rst), .enable_i(en), .tw0_i(tw0), .tw1_i(tw1), .tw2_i(tw2),
    .inv_hsync_i(ih), .inv_vsync_i(iv), .inv_pclk_i(ip),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .pclk_o(pc),
    .hpos_o(hp), .vpos_o(vp), .frame_done_o(fd)
  );

  int n_chk = 0, n_fail = 0, n_done = 0;
  bit finished = 0;

  // configuration as plain integers
  int c_hbp, c_hfp, c_hsw, c_ppl, c_lpp, c_vbp, c_vfp, c_vsw;

  // reference model state
  bit m_run = 0, m_ph = 0;
  int m_h = 0, m_v = 0;
  int g_abeg = 0, g_aend = 0, g_sbeg = 0, g_htot = 0;
  int g_vabeg = 0, g_vaend = 0, g_vsbeg = 0, g_vtot = 0;
  bit g_ih = 0, g_iv = 0, g_ip = 0;
  bit e_hs = 0, e_vs = 0, e_de = 0, e_pc = 0, e_fd = 0;
  int e_hp = 0, e_vp = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // field placement per R1, R2, R3
  task automatic set_cfg(int hbp, int hfp, int hsw, int ppl, int lpp,
                         int vbp, int vfp, int vsw, bit a_ih, bit a_iv, bit a_ip);
    logic [31:0] w0, w1, w2;
    c_hbp = hbp; c_hfp = hfp; c_hsw = hsw; c_ppl = ppl; c_lpp = lpp;
    c_vbp = vbp; c_vfp = vfp; c_vsw = vsw;
    w0 = '0; w1 = '0; w2 = '0;
    w0[31:24] = hbp[7:0]; w2[5:4] = hbp[9:8];
    w0[23:16] = hfp[7:0]; w2[1:0] = hfp[9:8];
    w0[15:10] = hsw[5:0]; w2[30:27] = hsw[9:6];
    w0[9:4] = ppl[5:0]; w0[3] = ppl[6];
    w1[9:0] = lpp[9:0]; w2[26] = lpp[10];
    w1[31:24] = vbp[7:0]; w1[23:16] = vfp[7:0]; w1[15:10] = vsw[5:0];
    tw0 = w0; tw1 = w1; tw2 = w2;
    ih = a_ih; iv = a_iv; ip = a_ip;
  endtask

  function automatic void latch_geom();
    g_abeg  = c_hbp + 1;
    g_aend  = g_abeg + (c_ppl + 1) * 16;
    g_sbeg  = g_aend + c_hfp + 1;
    g_htot  = g_sbeg + c_hsw + 1;
    g_vabeg = c_vbp;
    g_vaend = g_vabeg + c_lpp + 1;
    g_vsbeg = g_vaend + c_vfp;
    g_vtot  = g_vsbeg + c_vsw + 1;
    g_ih = ih; g_iv = iv; g_ip = ip;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_ph = 0; m_h = 0; m_v = 0;
      g_ih = 0; g_iv = 0; g_ip = 0;
      e_hs = 0; e_vs = 0; e_de = 0; e_pc = 0; e_fd = 0; e_hp = 0; e_vp = 0;
    end else begin
      if (m_run) begin
        e_hs = (m_h >= g_sbeg) ^ g_ih;
        e_vs = (m_v >= g_vsbeg) ^ g_iv;
        e_de = (m_h >= g_abeg && m_h < g_aend && m_v >= g_vabeg && m_v < g_vaend);
        e_pc = m_ph ^ g_ip;
        e_hp = m_h; e_vp = m_v;
      end else begin
        e_hs = g_ih; e_vs = g_iv; e_de = 0; e_pc = g_ip; e_hp = 0; e_vp = 0;
      end
      e_fd = m_run && m_ph && (m_h == g_htot - 1) && (m_v == g_vtot - 1) && !en;
      if (!m_run) begin
        if (en) begin
          latch_geom();
          m_run = 1; m_ph = 0; m_h = 0; m_v = 0;
        end
      end else if (!m_ph) begin
        m_ph = 1;
      end else begin
        m_ph = 0;
        m_h++;
        if (m_h == g_htot) begin
          m_h = 0;
          m_v++;
          if (m_v == g_vtot) begin
            m_v = 0;
            latch_geom();
            if (!en) m_run = 0;
          end
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1,R4,R8", "hsync", int'(hs), int'(e_hs));
      chk("R3,R5,R8", "vsync", int'(vs), int'(e_vs));
      chk("R2,R6,R10", "data enable", int'(de), int'(e_de));
      chk("R7", "pixel clock", int'(pc), int'(e_pc));
      chk("R9", "pixel position", int'(hp), e_hp);
      chk("R9", "line position", int'(vp), e_vp);
      chk("R11", "frame done", int'(fd), int'(e_fd));
      if (fd) n_done++;
    end
  end

  task automatic wait_done(int lim);
    int base = n_done;
    for (int i = 0; i < lim && n_done == base; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11", "frame done pulses after disable", n_done - base, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_cfg(1, 0, 2, 0, 3, 1, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    // R12 reset state
    chk("R12", "hsync in reset", int'(hs), 0);
    chk("R12", "vsync in reset", int'(vs), 0);
    chk("R12", "de in reset", int'(de), 0);
    chk("R12", "done in reset", int'(fd), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;                      // R9 start from idle
    repeat (400) @(negedge clk);
    // R10: mid-frame write, must only apply at the next frame
    set_cfg(0, 2, 0, 1, 2, 0, 2, 2, 1, 1, 1);
    repeat (500) @(negedge clk);
    // R11: short enable drop inside a frame has no effect
    en = 1'b0;
    repeat (4) @(negedge clk);
    en = 1'b1;
    repeat (300) @(negedge clk);
    chk("R11", "no done pulse after brief enable drop", n_done, 0);
    en = 1'b0;
    wait_done(3000);
    repeat (20) @(negedge clk);
    // R1, R2: upper field bits in use
    set_cfg(259, 257, 65, 64, 1, 2, 1, 1, 1, 0, 1);
    en = 1'b1;
    repeat (50) @(negedge clk);
    en = 1'b0;
    wait_done(30000);
    repeat (20) @(negedge clk);
    // R3: line count above 1024, zero vertical porches
    set_cfg(0, 0, 0, 0, 1024, 0, 0, 0, 0, 1, 0);
    en = 1'b1;
    repeat (50) @(negedge clk);
    en = 1'b0;
    wait_done(45000);
    repeat (20) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule